// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block brings up a downstream FPGA that takes its configuration as a plain clocked serial stream. When a start request is accepted, the block first looks at the target's DONE status. If the target already reports itself configured, the run ends at once and the program line is left alone. Otherwise the block drives the target's program line through a fixed pulse pattern. It then polls INIT until the target is ready and streams a fixed-length bitstream out of a byte-wide memory port, one bit per serial clock. At the end it waits for DONE.

The program output is an enable with inverted sense: driving it high makes the board pull the target's program pin low, and driving it low lets the pin float. INIT and DONE arrive from another clock domain and pass through two flip-flop stages before use. Both waits are bounded by timeouts, and a timeout ends the run with an error flag. The serial clock comes from the system clock through a parameterised divider.

Top module: `bitload_seq`

## Requirements
- R1: If the synchronised DONE input is high when a start request is accepted in idle, the run finishes with fin_o=1 and err_o=0 on the next cycle. busy_o stays low, prog_oe_o stays low and no memory request is made.
- R2: Otherwise prog_oe_o goes high for PROG_DLY cycles, then low for PROG_DLY cycles, then high again. It stays high until the run returns to idle, and it is low in idle.
- R3: No memory request is made and no CCLK edge is produced until the synchronised INIT input has been seen high. INIT is sampled once every POLL_DLY cycles.
- R4: Exactly BYTE_COUNT bytes are fetched per run, from consecutive addresses starting at BASE_ADDR.
- R5: mem_req_o stays high with a stable mem_addr_o until mem_valid_i is high. mem_data_i is taken in the cycle where mem_req_o and mem_valid_i are both high.
- R6: Each byte leaves on din_o LSB first, with 8 CCLK pulses per byte, each phase lasting CLK_DIV system cycles. din_o changes only as CCLK falls. A new byte is requested only after all 8 bits of the previous byte have been sent.
- R7: After the last byte the block waits for synchronised DONE high, then returns to idle with fin_o=1 and err_o=0.
- R8: If INIT is not seen high within INIT_TMO cycles of the end of the program pulse, the run ends with fin_o=1 and err_o=1 and no byte is sent.
- R9: If DONE is not seen high within DONE_TMO cycles after the last byte, the run ends with fin_o=1 and err_o=1.
- R10: busy_o is high from the cycle after an accepted start until the return to idle. An accepted start clears fin_o and err_o. A start request while busy has no effect.
- R11: After reset busy_o, fin_o, err_o, prog_oe_o, mem_req_o and cclk_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled in idle |
| busy_o | output | 1 | Run in progress |
| fin_o | output | 1 | Last run finished (held until next start) |
| err_o | output | 1 | Last run ended by a timeout (held until next start) |
| mem_req_o | output | 1 | Byte request to bitstream memory |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_valid_i | input | 1 | Memory returns the requested byte |
| mem_data_i | input | 8 | Returned byte |
| prog_oe_o | output | 1 | Program-pin pull-down enable (high pulls the pin low) |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| init_i | input | 1 | Target INIT status, asynchronous |
| done_i | input | 1 | Target DONE status, asynchronous |

## Verification
The bench builds the loader with a 4-byte bitstream at base address 0x100, a divider of 2, 5-cycle program phases, a 3-cycle poll interval and 60-cycle timeouts. With these values every run finishes in a few hundred cycles. One vector table can then drive the skip path, both timeout paths, slow memory responses, late INIT and DONE, and a start request made mid-stream. A behavioural target model decodes the serial stream on CCLK and compares every byte with the value computed from its address.

// File: rtl/bitload_pkg.sv
package bitload_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PGM_A = 3'd1,
    ST_PGM_B = 3'd2,
    ST_INIT  = 3'd3,
    ST_FETCH = 3'd4,
    ST_SHIFT = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bitload_sync.sv
module bitload_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end

endmodule

// File: rtl/bitload_shift.sv
module bitload_shift #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       idle_o,
  output logic       cclk_o,
  output logic       din_o
);

  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             busy_q, busy_d;
  logic [7:0]       sreg_q, sreg_d;
  logic [2:0]       bit_q, bit_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             cclk_q, cclk_d;
  logic             en;

  always_comb begin
    busy_d = busy_q;
    sreg_d = sreg_q;
    bit_d  = bit_q;
    div_d  = div_q;
    cclk_d = cclk_q;
    en     = 1'b0;
    if (!busy_q) begin
      if (load_i) begin
        en     = 1'b1;
        busy_d = 1'b1;
        sreg_d = data_i;
        bit_d  = '0;
        div_d  = '0;
        cclk_d = 1'b0;
      end
    end else begin
      en = 1'b1;
      if (div_q == DIV_LAST) begin
        div_d = '0;
        if (!cclk_q) begin
          cclk_d = 1'b1;
        end else begin
          cclk_d = 1'b0;
          sreg_d = {1'b0, sreg_q[7:1]};
          if (bit_q == 3'd7) begin
            busy_d = 1'b0;
          end else begin
            bit_d = bit_q + 3'd1;
          end
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sreg_q <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      cclk_q <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
      div_q  <= div_d;
      cclk_q <= cclk_d;
    end
  end

  assign idle_o = !busy_q;
  assign cclk_o = cclk_q;
  assign din_o  = sreg_q[0];

endmodule

// File: rtl/bitload_ctrl.sv
module bitload_ctrl
  import bitload_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 24,
  parameter int unsigned        BYTE_COUNT = 169216,
  parameter logic [ADDR_W-1:0]  BASE_ADDR  = '0,
  parameter int unsigned        PROG_DLY   = 200,
  parameter int unsigned        POLL_DLY   = 200,
  parameter int unsigned        INIT_TMO   = 1000000,
  parameter int unsigned        DONE_TMO   = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              init_s_i,
  input  logic              done_s_i,
  input  logic              sh_idle_i,
  input  logic              mem_valid_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              err_o,
  output logic              prog_oe_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              sh_load_o
);

  localparam int unsigned DLY_MAX = max2(PROG_DLY, POLL_DLY);
  localparam int unsigned TMO_MAX = max2(INIT_TMO, DONE_TMO);
  localparam int unsigned DLY_W   = $clog2(DLY_MAX + 1);
  localparam int unsigned TMO_W   = $clog2(TMO_MAX + 1);
  localparam int unsigned CNT_W   = $clog2(BYTE_COUNT + 1);

  localparam logic [DLY_W-1:0] PROG_LAST = DLY_W'(PROG_DLY - 1);
  localparam logic [DLY_W-1:0] POLL_LAST = DLY_W'(POLL_DLY - 1);
  localparam logic [TMO_W-1:0] INIT_LAST = TMO_W'(INIT_TMO - 1);
  localparam logic [TMO_W-1:0] DONE_LAST = TMO_W'(DONE_TMO - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_COUNT - 1);

  seq_state_t        state_q, state_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              fin_q, fin_d;
  logic              err_q, err_d;
  logic              ptr_en, flag_en;

  always_comb begin
    state_d   = state_q;
    dly_d     = dly_q;
    tmo_d     = tmo_q;
    idx_d     = idx_q;
    addr_d    = addr_q;
    fin_d     = fin_q;
    err_d     = err_q;
    ptr_en    = 1'b0;
    flag_en   = 1'b0;
    sh_load_o = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          flag_en = 1'b1;
          err_d   = 1'b0;
          if (done_s_i) begin
            fin_d = 1'b1;
          end else begin
            fin_d   = 1'b0;
            dly_d   = '0;
            state_d = ST_PGM_A;
          end
        end
      end
      ST_PGM_A: begin
        if (dly_q == PROG_LAST) begin
          dly_d   = '0;
          state_d = ST_PGM_B;
        end else begin
          dly_d = dly_q + DLY_W'(1);
        end
      end
      ST_PGM_B: begin
        if (dly_q == PROG_LAST) begin
          dly_d   = '0;
          tmo_d   = '0;
          state_d = ST_INIT;
        end else begin
          dly_d = dly_q + DLY_W'(1);
        end
      end
      ST_INIT: begin
        tmo_d = tmo_q + TMO_W'(1);
        if (dly_q == POLL_LAST) begin
          dly_d = '0;
        end else begin
          dly_d = dly_q + DLY_W'(1);
        end
        if (dly_q == POLL_LAST && init_s_i) begin
          ptr_en  = 1'b1;
          idx_d   = '0;
          addr_d  = BASE_ADDR;
          state_d = ST_FETCH;
        end else if (tmo_q == INIT_LAST) begin
          flag_en = 1'b1;
          fin_d   = 1'b1;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_FETCH: begin
        if (mem_valid_i && sh_idle_i) begin
          sh_load_o = 1'b1;
          state_d   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (sh_idle_i) begin
          if (idx_q == BYTE_LAST) begin
            tmo_d   = '0;
            state_d = ST_DONE;
          end else begin
            ptr_en  = 1'b1;
            idx_d   = idx_q + CNT_W'(1);
            addr_d  = addr_q + ADDR_W'(1);
            state_d = ST_FETCH;
          end
        end
      end
      ST_DONE: begin
        tmo_d = tmo_q + TMO_W'(1);
        if (done_s_i) begin
          flag_en = 1'b1;
          fin_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (tmo_q == DONE_LAST) begin
          flag_en = 1'b1;
          fin_d   = 1'b1;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      tmo_q   <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      addr_q <= '0;
    end else if (ptr_en) begin
      idx_q  <= idx_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q <= 1'b0;
      err_q <= 1'b0;
    end else if (flag_en) begin
      fin_q <= fin_d;
      err_q <= err_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign fin_o      = fin_q;
  assign err_o      = err_q;
  assign prog_oe_o  = (state_q != ST_IDLE) && (state_q != ST_PGM_B);
  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = addr_q;

endmodule

// File: rtl/bitload_seq.sv
module bitload_seq
  import bitload_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 24,
  parameter int unsigned       BYTE_COUNT = 169216,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
  parameter int unsigned       CLK_DIV    = 4,
  parameter int unsigned       PROG_DLY   = 200,
  parameter int unsigned       POLL_DLY   = 200,
  parameter int unsigned       INIT_TMO   = 1000000,
  parameter int unsigned       DONE_TMO   = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  output logic              prog_oe_o,
  output logic              cclk_o,
  output logic              din_o,
  input  logic              init_i,
  input  logic              done_i
);

  logic [1:0] pins_sy;
  logic       init_sy, done_sy;
  logic       sh_idle, sh_load;

  bitload_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({done_i, init_i}),
    .sync_o  (pins_sy)
  );

  assign init_sy = pins_sy[0];
  assign done_sy = pins_sy[1];

  bitload_ctrl #(
    .ADDR_W     (ADDR_W),
    .BYTE_COUNT (BYTE_COUNT),
    .BASE_ADDR  (BASE_ADDR),
    .PROG_DLY   (PROG_DLY),
    .POLL_DLY   (POLL_DLY),
    .INIT_TMO   (INIT_TMO),
    .DONE_TMO   (DONE_TMO)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .init_s_i    (init_sy),
    .done_s_i    (done_sy),
    .sh_idle_i   (sh_idle),
    .mem_valid_i (mem_valid_i),
    .busy_o      (busy_o),
    .fin_o       (fin_o),
    .err_o       (err_o),
    .prog_oe_o   (prog_oe_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .sh_load_o   (sh_load)
  );

  bitload_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (sh_load),
    .data_i (mem_data_i),
    .idle_o (sh_idle),
    .cclk_o (cclk_o),
    .din_o  (din_o)
  );

endmodule

// File: rtl/bitload_seq_chk.sv
module bitload_seq_chk #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned BYTE_COUNT = 169216
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              fin_o,
  input logic              err_o,
  input logic              prog_oe_o,
  input logic              cclk_o,
  input logic              din_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic              init_sy,
  input logic              done_sy,
  input logic              sh_idle
);

  localparam int unsigned CW = $clog2(BYTE_COUNT + 1) + 1;

  logic          seen_init_q;
  logic [CW-1:0] taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_init_q <= 1'b0;
      taken_q     <= '0;
    end else if (!busy_o) begin
      seen_init_q <= 1'b0;
      taken_q     <= '0;
    end else begin
      if (init_sy) seen_init_q <= 1'b1;
      if (mem_req_o && mem_valid_i) taken_q <= taken_q + CW'(1);
    end
  end

  assert_skip_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && done_sy) |=> (!busy_o && !prog_oe_o && fin_o && !err_o));

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!prog_oe_o && !mem_req_o && !cclk_o));

  assert_no_data_before_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o || $rose(cclk_o)) |-> seen_init_q);

  assert_byte_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_valid_i) |-> (taken_q < CW'(BYTE_COUNT)));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> sh_idle);

  assert_din_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_o && $past(cclk_o)) |-> $stable(din_o));

  assert_success_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fin_o) && !err_o && $past(busy_o)) |-> $past(done_sy));

endmodule

bind bitload_seq bitload_seq_chk #(
  .ADDR_W     (ADDR_W),
  .BYTE_COUNT (BYTE_COUNT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .fin_o       (fin_o),
  .err_o       (err_o),
  .prog_oe_o   (prog_oe_o),
  .cclk_o      (cclk_o),
  .din_o       (din_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_valid_i (mem_valid_i),
  .init_sy     (init_sy),
  .done_sy     (done_sy),
  .sh_idle     (sh_idle)
);

// File: tb/tb_bitload_seq.sv
`timescale 1ns/1ps
module tb_bitload_seq;

  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned NBYTES   = 4;
  localparam logic [11:0] BASE     = 12'h100;
  localparam int unsigned DIV      = 2;
  localparam int unsigned PDLY     = 5;
  localparam int unsigned POLL     = 3;
  localparam int unsigned TMO      = 60;
  localparam logic [7:0]  NEVER    = 8'hFF;

  typedef struct packed {
    logic       done0;
    logic [7:0] init_dly;
    logic [7:0] done_dly;
    logic [3:0] lat;
    logic       restart;
    logic       exp_err;
    logic [3:0] exp_bytes;
    logic [1:0] exp_rises;
  } case_t;

  localparam int NCASE = 6;
  localparam case_t CASES [NCASE] = '{
    '{1'b1, 8'd0,  8'd0,  4'd0, 1'b0, 1'b0, 4'd0, 2'd0},
    '{1'b0, 8'd10, 8'd5,  4'd0, 1'b0, 1'b0, 4'd4, 2'd2},
    '{1'b0, 8'd30, 8'd20, 4'd3, 1'b0, 1'b0, 4'd4, 2'd2},
    '{1'b0, NEVER, 8'd0,  4'd1, 1'b0, 1'b1, 4'd0, 2'd2},
    '{1'b0, 8'd4,  NEVER, 4'd2, 1'b0, 1'b1, 4'd4, 2'd2},
    '{1'b0, 8'd2,  8'd0,  4'd1, 1'b1, 1'b0, 4'd4, 2'd2}
  };

  logic              clk, rst_n, start_i;
  logic              busy_o, fin_o, err_o, mem_req_o, mem_valid_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [7:0]        mem_data_i;
  logic              prog_oe_o, cclk_o, din_o, init_i, done_i;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  bitload_seq #(
    .ADDR_W(ADDR_W), .BYTE_COUNT(NBYTES), .BASE_ADDR(BASE), .CLK_DIV(DIV),
    .PROG_DLY(PDLY), .POLL_DLY(POLL), .INIT_TMO(TMO), .DONE_TMO(TMO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .fin_o(fin_o), .err_o(err_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i), .prog_oe_o(prog_oe_o),
    .cclk_o(cclk_o), .din_o(din_o), .init_i(init_i), .done_i(done_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // serial capture on rising CCLK, LSB first
  logic [7:0] cap_mem [0:127];
  int         cap_n    = 0;
  int         cap_bits = 0;
  int         early    = 0;
  logic [7:0] cap_sh   = '0;
  always @(posedge cclk_o) begin
    if (!init_i) early++;
    cap_sh = {din_o, cap_sh[7:1]};
    cap_bits++;
    if (cap_bits % 8 == 0) begin
      if (cap_n < 128) cap_mem[cap_n] = cap_sh;
      cap_n++;
    end
  end

  function automatic logic [7:0] mem_val(input logic [ADDR_W-1:0] a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input case_t c, input int id);
    int base_n, base_early, rises, low_len, n, init_cnt, done_cnt, lat_cnt;
    logic prev_oe, in_low, first_req_seen;
    logic [ADDR_W-1:0] first_addr;
    int first_busy, first_fin;
    base_n = cap_n; base_early = early;
    rises = 0; low_len = 0; in_low = 1'b0; prev_oe = 1'b0;
    init_cnt = 0; done_cnt = 0; lat_cnt = 0; first_req_seen = 1'b0;
    first_addr = '0; first_busy = 0; first_fin = 1;
    @(negedge clk);
    init_i = 1'b0; done_i = c.done0; mem_valid_i = 1'b0;
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    first_busy = busy_o; first_fin = fin_o;
    n = 0;
    while ((busy_o || n < 2) && n < 3000) begin
      // program line observation
      if (prog_oe_o && !prev_oe) begin rises++; in_low = 1'b0; end
      if (!prog_oe_o && prev_oe) in_low = 1'b1;
      if (in_low && !prog_oe_o) low_len++;
      prev_oe = prog_oe_o;
      // target INIT model
      if (rises == 2 && prog_oe_o && c.init_dly != NEVER) begin
        if (init_cnt >= int'(c.init_dly)) init_i = 1'b1;
        init_cnt++;
      end
      // target DONE model
      if (cap_n - base_n == NBYTES && c.done_dly != NEVER) begin
        if (done_cnt >= int'(c.done_dly)) done_i = 1'b1;
        done_cnt++;
      end
      // memory model
      if (mem_valid_i) begin
        mem_valid_i = 1'b0;
        lat_cnt = 0;
      end else if (mem_req_o) begin
        if (!first_req_seen) begin first_req_seen = 1'b1; first_addr = mem_addr_o; end
        if (lat_cnt >= int'(c.lat)) begin
          mem_valid_i = 1'b1;
          mem_data_i  = mem_val(mem_addr_o);
        end else lat_cnt++;
      end
      // start request while busy (R10)
      if (c.restart && (n == 40 || n == 41)) start_i = (n == 40);
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    mem_valid_i = 1'b0;
    if (c.done0) begin
      check("R1", $sformatf("case%0d busy after start", id), first_busy, 0);
    end else begin
      check("R10", $sformatf("case%0d busy after start", id), first_busy, 1);
      check("R10", $sformatf("case%0d fin cleared", id), first_fin, 0);
    end
    check(c.exp_err ? (c.exp_bytes == 0 ? "R8" : "R9") : (c.done0 ? "R1" : "R7"),
          $sformatf("case%0d fin", id), fin_o, 1);
    check(c.exp_err ? (c.exp_bytes == 0 ? "R8" : "R9") : (c.done0 ? "R1" : "R7"),
          $sformatf("case%0d err", id), err_o, int'(c.exp_err));
    check(c.restart ? "R10" : "R2", $sformatf("case%0d prog rises", id), rises, int'(c.exp_rises));
    if (rises >= 2) check("R2", $sformatf("case%0d prog low length", id), low_len, PDLY);
    check("R4", $sformatf("case%0d bytes sent", id), cap_n - base_n, int'(c.exp_bytes));
    check("R3", $sformatf("case%0d cclk before init", id), early - base_early, 0);
    if (c.exp_bytes != 0) begin
      check("R4", $sformatf("case%0d first address", id), int'(first_addr), int'(BASE));
      for (int k = 0; k < int'(c.exp_bytes); k++)
        check("R6", $sformatf("case%0d byte %0d", id, k),
              int'(cap_mem[base_n + k]), int'(mem_val(BASE + ADDR_W'(k))));
    end else begin
      check("R3", $sformatf("case%0d no memory request", id), int'(first_req_seen), 0);
    end
    check("R2", $sformatf("case%0d prog released in idle", id), prog_oe_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mem_valid_i = 1'b0; mem_data_i = '0;
    init_i = 1'b0; done_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "busy after reset", busy_o, 0);
    check("R11", "fin after reset", fin_o, 0);
    check("R11", "err after reset", err_o, 0);
    check("R11", "prog_oe after reset", prog_oe_o, 0);
    check("R11", "mem_req after reset", mem_req_o, 0);
    check("R11", "cclk after reset", cclk_o, 0);

    for (int i = 0; i < NCASE; i++) run_case(CASES[i], i);

    // R5: request held while memory is slow, address unchanged
    begin
      int held;
      logic [ADDR_W-1:0] a0;
      held = 0;
      @(negedge clk);
      init_i = 1'b1; done_i = 1'b0;
      repeat (4) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      while (!mem_req_o && held < 500) begin @(negedge clk); held++; end
      a0 = mem_addr_o;
      repeat (10) @(negedge clk);
      check("R5", "request held without valid", mem_req_o, 1);
      check("R5", "address stable without valid", int'(mem_addr_o), int'(a0));
      check("R6", "no serial clock while waiting", cclk_o, 0);
      // R11: asynchronous reset in the middle of a run
      rst_n = 1'b0;
      @(negedge clk);
      check("R11", "busy after mid-run reset", busy_o, 0);
      check("R11", "prog_oe after mid-run reset", prog_oe_o, 0);
      check("R11", "mem_req after mid-run reset", mem_req_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule